// File: doc/BRIEF.md
# Memory Barrier Ordering Unit

This unit sits between an in-order issue stage and the load/store datapath of a processor core and enforces typed memory barriers. Every issued operation carries a class code; a barrier also carries a 5-bit barrier type (the field at bits [10:6] of the barrier instruction word, whose other fields are a 6-bit major opcode 000000 at the top, a 5-bit zero field, a 10-bit minor opcode 0110101101 and a 6-bit function code 111100 at the bottom). The type picks which older classes must drain before the barrier retires, whether draining means reaching the ordering point or being globally performed, and which younger classes are held at issue meanwhile.

Outstanding loads, stores, cache-maintenance/prefetch operations and global invalidate operations are tracked by counters that rise on accepted issues and fall on acknowledge pulses from the memory side. When a barrier is accepted, each counter's value is copied into a drain counter, so younger traffic of an ungated class can flow without lengthening the barrier. Acknowledges of one class are assumed to return in issue order. The barrier raises no exception; it only stalls.

Top module: `mem_barrier_unit`

## Requirements
- R1: After reset `bar_pending` and `bar_done` are low, all counters are empty and `iss_ready` is high for every class code.
- R2: Class codes: 0 load, 1 store, 2 cache maintenance or prefetch, 3 global invalidate or instruction-cache sync, 4 barrier; codes 5 to 7 are non-memory operations and are always ready.
- R3: Each memory class holds up to 16 outstanding operations per acknowledge kind; with 16 outstanding, issue of that class stalls until an acknowledge arrives, and an acknowledge with nothing outstanding is ignored.
- R4: Type 0x00 waits until all older loads, stores and maintenance operations are globally performed (`glb_ack`) and holds younger loads, stores and maintenance operations.
- R5: Type 0x04 waits for older stores to reach the ordering point (`ord_ack`) and holds younger stores only; loads pass.
- R6: Type 0x10 waits for older loads and stores to reach the ordering point only, and holds younger loads and stores.
- R7: Type 0x11 waits for older loads at the ordering point and holds younger loads and stores.
- R8: Type 0x12 waits for older loads and stores at the ordering point and holds younger stores only.
- R9: Type 0x13 waits for older loads at the ordering point and holds younger loads only.
- R10: Type 0x14 with `gi_enable` high behaves as 0x10 and also waits until every older global invalidate operation is acknowledged on `ginv_ack`; with `gi_enable` low it behaves as 0x00.
- R11: Every other type (0x01-0x03, 0x05-0x0F, 0x15-0x1F) behaves exactly as 0x00.
- R12: The maintenance class (code 2) is waited for whenever loads or stores are waited for, and held whenever loads or stores are held.
- R13: One barrier at a time: `bar_pending` rises the cycle after acceptance, a barrier class is not ready while one is pending, and in the first cycle in which all required drain counts are zero the next edge clears `bar_pending` and raises `bar_done` for one cycle.
- R14: Younger operations of classes the barrier does not hold are accepted while it is pending and do not delay its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gi_enable | input | 1 | Enables the distinct meaning of barrier type 0x14 |
| iss_valid | input | 1 | Issue request valid |
| iss_class | input | 3 | Operation class code of the request |
| iss_btype | input | 5 | Barrier type, used when the class is barrier |
| iss_ready | output | 1 | Request accepted when high together with iss_valid |
| ord_ack | input | 3 | Per class (load, store, maintenance): one operation reached the ordering point |
| glb_ack | input | 3 | Per class: one operation became globally performed |
| ginv_ack | input | 1 | One global invalidate operation completed system-wide |
| bar_pending | output | 1 | A barrier is held |
| bar_done | output | 1 | One-cycle pulse when the held barrier retires |

## Verification
Every cycle the assertions check that counters never pass their capacity, that drain counts never exceed the outstanding counts, that no held class or second barrier is accepted while a barrier is pending, and that the retire pulse lasts one cycle. Whether each barrier type waits on the right classes and acknowledge kind, whether ungated younger traffic is kept out of the drain, and the treatment of reserved and vendor types are only visible in the bench's scenarios, which compare ready, pending and retire timing against a model built from the requirements.

// File: rtl/mbu_pkg.sv
package mbu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_MAINT   = 3'd2,
    OP_GINV    = 3'd3,
    OP_BARRIER = 3'd4
  } op_class_e;

  localparam logic [4:0] BT_COMPLETE  = 5'h00;
  localparam logic [4:0] BT_STORE_ORD = 5'h04;
  localparam logic [4:0] BT_ORDER     = 5'h10;
  localparam logic [4:0] BT_ACQUIRE   = 5'h11;
  localparam logic [4:0] BT_RELEASE   = 5'h12;
  localparam logic [4:0] BT_LOAD_ORD  = 5'h13;
  localparam logic [4:0] BT_INVAL     = 5'h14;

  localparam int NUM_MEM_CLASSES = 3;

  typedef struct packed {
    logic wait_ld;
    logic wait_st;
    logic wait_gv;
    logic use_glb;
    logic gate_ld;
    logic gate_st;
  } bar_cfg_t;

  function automatic bar_cfg_t btype_to_cfg(input logic [4:0] bt, input logic gi_en);
    bar_cfg_t c;
    c = '{wait_ld: 1'b1, wait_st: 1'b1, wait_gv: 1'b0, use_glb: 1'b1,
          gate_ld: 1'b1, gate_st: 1'b1};
    case (bt)
      BT_STORE_ORD: c = '{wait_ld: 1'b0, wait_st: 1'b1, wait_gv: 1'b0, use_glb: 1'b0,
                          gate_ld: 1'b0, gate_st: 1'b1};
      BT_ORDER:     c = '{wait_ld: 1'b1, wait_st: 1'b1, wait_gv: 1'b0, use_glb: 1'b0,
                          gate_ld: 1'b1, gate_st: 1'b1};
      BT_ACQUIRE:   c = '{wait_ld: 1'b1, wait_st: 1'b0, wait_gv: 1'b0, use_glb: 1'b0,
                          gate_ld: 1'b1, gate_st: 1'b1};
      BT_RELEASE:   c = '{wait_ld: 1'b1, wait_st: 1'b1, wait_gv: 1'b0, use_glb: 1'b0,
                          gate_ld: 1'b0, gate_st: 1'b1};
      BT_LOAD_ORD:  c = '{wait_ld: 1'b1, wait_st: 1'b0, wait_gv: 1'b0, use_glb: 1'b0,
                          gate_ld: 1'b1, gate_st: 1'b0};
      BT_INVAL: begin
        if (gi_en)
          c = '{wait_ld: 1'b1, wait_st: 1'b1, wait_gv: 1'b1, use_glb: 1'b0,
                gate_ld: 1'b1, gate_st: 1'b1};
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mbu_decode.sv
module mbu_decode
  import mbu_pkg::*;
(
  input  logic [4:0] btype,
  input  logic       gi_en,
  output bar_cfg_t   cfg
);

  always_comb cfg = btype_to_cfg(btype, gi_en);

endmodule

// File: rtl/mbu_track.sv
module mbu_track #(
  parameter int MAX_OUT = 16,
  parameter int CW      = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  input  logic snap,
  output logic full,
  output logic drained
);

  localparam logic [CW-1:0] CAP = CW'(MAX_OUT);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] drn_q, drn_d;
  logic          inc_ok, dec_ok;

  always_comb begin
    inc_ok = inc && (cnt_q != CAP);
    dec_ok = dec && (cnt_q != '0);
    cnt_d  = cnt_q;
    if (inc_ok) cnt_d = cnt_d + ONE;
    if (dec_ok) cnt_d = cnt_d - ONE;
    if (snap)
      drn_d = cnt_d;
    else if (dec && (drn_q != '0))
      drn_d = drn_q - ONE;
    else
      drn_d = drn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      drn_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      drn_q <= drn_d;
    end
  end

  assign full    = (cnt_q == CAP);
  assign drained = (drn_q == '0);

  // R3
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= CAP);
  // R3
  full_no_inc_chk: assert property (@(posedge clk) disable iff (rst) full |-> !inc);
  // R14
  drain_bound_chk: assert property (@(posedge clk) disable iff (rst) drn_q <= cnt_q);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec) |=> $stable(cnt_q));

endmodule

// File: rtl/mbu_ctrl.sv
module mbu_ctrl
  import mbu_pkg::*;
#(
  parameter int NCLS = NUM_MEM_CLASSES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bar_acc,
  input  bar_cfg_t        cfg_in,
  input  logic [NCLS-1:0] ord_drained,
  input  logic [NCLS-1:0] glb_drained,
  input  logic            gv_drained,
  output logic            pend,
  output logic            done,
  output bar_cfg_t        cfg_q
);

  logic [NCLS-1:0] need;
  logic [NCLS-1:0] cls_ok;
  logic            all_clear;

  // class 0 loads, class 1 stores, class 2 maintenance (counts as both)
  always_comb begin
    need[0] = cfg_q.wait_ld;
    need[1] = cfg_q.wait_st;
    need[2] = cfg_q.wait_ld | cfg_q.wait_st;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_ok
    assign cls_ok[c] = !need[c] || (cfg_q.use_glb ? glb_drained[c] : ord_drained[c]);
  end

  assign all_clear = (&cls_ok) && (!cfg_q.wait_gv || gv_drained);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      done  <= 1'b0;
      cfg_q <= '0;
    end else begin
      done <= pend && all_clear;
      if (bar_acc) begin
        pend  <= 1'b1;
        cfg_q <= cfg_in;
      end else if (pend && all_clear) begin
        pend <= 1'b0;
      end
    end
  end

  // R13
  no_reaccept_chk: assert property (@(posedge clk) disable iff (rst) pend |-> !bar_acc);
  // R13
  done_clears_chk: assert property (@(posedge clk) disable iff (rst) done |-> !pend);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

endmodule

// File: rtl/mem_barrier_unit.sv
module mem_barrier_unit
  import mbu_pkg::*;
#(
  parameter int MAX_OUT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gi_enable,
  input  logic       iss_valid,
  input  logic [2:0] iss_class,
  input  logic [4:0] iss_btype,
  output logic       iss_ready,
  input  logic [2:0] ord_ack,
  input  logic [2:0] glb_ack,
  input  logic       ginv_ack,
  output logic       bar_pending,
  output logic       bar_done
);

  localparam int NCLS = NUM_MEM_CLASSES;
  localparam int CW   = $clog2(MAX_OUT + 1);

  bar_cfg_t        dec_cfg, cfg_q;
  logic [NCLS-1:0] ord_full, glb_full, ord_drained, glb_drained;
  logic [NCLS-1:0] cls_inc, cls_gate;
  logic            gv_full, gv_drained;
  logic            acc, bar_acc;

  mbu_decode u_decode (
    .btype (iss_btype),
    .gi_en (gi_enable),
    .cfg   (dec_cfg)
  );

  always_comb begin
    cls_gate[0] = bar_pending && cfg_q.gate_ld;
    cls_gate[1] = bar_pending && cfg_q.gate_st;
    cls_gate[2] = bar_pending && (cfg_q.gate_ld || cfg_q.gate_st);
  end

  always_comb begin
    case (iss_class)
      OP_LOAD:    iss_ready = !ord_full[0] && !glb_full[0] && !cls_gate[0];
      OP_STORE:   iss_ready = !ord_full[1] && !glb_full[1] && !cls_gate[1];
      OP_MAINT:   iss_ready = !ord_full[2] && !glb_full[2] && !cls_gate[2];
      OP_GINV:    iss_ready = !gv_full;
      OP_BARRIER: iss_ready = !bar_pending;
      default:    iss_ready = 1'b1;
    endcase
  end

  assign acc     = iss_valid && iss_ready;
  assign bar_acc = acc && (iss_class == OP_BARRIER);

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign cls_inc[c] = acc && (iss_class == 3'(c));

    mbu_track #(.MAX_OUT(MAX_OUT), .CW(CW)) u_ord (
      .clk     (clk),
      .rst     (rst),
      .inc     (cls_inc[c]),
      .dec     (ord_ack[c]),
      .snap    (bar_acc),
      .full    (ord_full[c]),
      .drained (ord_drained[c])
    );

    mbu_track #(.MAX_OUT(MAX_OUT), .CW(CW)) u_glb (
      .clk     (clk),
      .rst     (rst),
      .inc     (cls_inc[c]),
      .dec     (glb_ack[c]),
      .snap    (bar_acc),
      .full    (glb_full[c]),
      .drained (glb_drained[c])
    );
  end

  mbu_track #(.MAX_OUT(MAX_OUT), .CW(CW)) u_ginv (
    .clk     (clk),
    .rst     (rst),
    .inc     (acc && (iss_class == OP_GINV)),
    .dec     (ginv_ack),
    .snap    (bar_acc),
    .full    (gv_full),
    .drained (gv_drained)
  );

  mbu_ctrl #(.NCLS(NCLS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bar_acc     (bar_acc),
    .cfg_in      (dec_cfg),
    .ord_drained (ord_drained),
    .glb_drained (glb_drained),
    .gv_drained  (gv_drained),
    .pend        (bar_pending),
    .done        (bar_done),
    .cfg_q       (cfg_q)
  );

  // R13
  one_barrier_chk: assert property (@(posedge clk) disable iff (rst)
    bar_pending |-> !(iss_valid && iss_class == OP_BARRIER && iss_ready));
  // R13
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst) bar_acc |=> bar_pending);
  // R4
  gate_load_chk: assert property (@(posedge clk) disable iff (rst)
    (bar_pending && cfg_q.gate_ld) |-> !(acc && iss_class == OP_LOAD));
  // R5
  gate_store_chk: assert property (@(posedge clk) disable iff (rst)
    (bar_pending && cfg_q.gate_st) |-> !(acc && iss_class == OP_STORE));
  // R12
  gate_maint_chk: assert property (@(posedge clk) disable iff (rst)
    (bar_pending && (cfg_q.gate_ld || cfg_q.gate_st)) |-> !(acc && iss_class == OP_MAINT));
  // R2
  other_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_class > 3'd4) |-> iss_ready);

endmodule

// File: tb/mem_barrier_unit_tb.sv
module mem_barrier_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CAP        = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gi_enable = 1'b0;
  logic       iss_valid = 1'b0;
  logic [2:0] iss_class = 3'd5;
  logic [4:0] iss_btype = 5'd0;
  logic       iss_ready;
  logic [2:0] ord_ack = 3'b000;
  logic [2:0] glb_ack = 3'b000;
  logic       ginv_ack = 1'b0;
  logic       bar_pending;
  logic       bar_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_barrier_unit #(.MAX_OUT(CAP)) u_dut (
    .clk (clk), .rst (rst), .gi_enable (gi_enable),
    .iss_valid (iss_valid), .iss_class (iss_class), .iss_btype (iss_btype),
    .iss_ready (iss_ready), .ord_ack (ord_ack), .glb_ack (glb_ack),
    .ginv_ack (ginv_ack), .bar_pending (bar_pending), .bar_done (bar_done)
  );

  int oc[3], gc[3], od[3], gd[3];
  int vc, vd;
  bit mp, md;
  bit e_wl, e_ws, e_wg, e_glb, e_gl, e_gs;
  int n_run = 0, n_fail = 0;

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit m_ready(input int cls);
    case (cls)
      0: return oc[0] < CAP && gc[0] < CAP && !(mp && e_gl);
      1: return oc[1] < CAP && gc[1] < CAP && !(mp && e_gs);
      2: return oc[2] < CAP && gc[2] < CAP && !(mp && (e_gl || e_gs));
      3: return vc < CAP;
      4: return !mp;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit m_zero(input int c);
    return e_glb ? (gd[c] == 0) : (od[c] == 0);
  endfunction

  function automatic bit m_clear();
    return (!e_wl || m_zero(0)) && (!e_ws || m_zero(1)) &&
           (!(e_wl || e_ws) || m_zero(2)) && (!e_wg || vd == 0);
  endfunction

  task automatic set_cfg(input int bt, input bit gi);
    {e_wl, e_ws, e_wg, e_glb, e_gl, e_gs} = 6'b110111;
    case (bt)
      'h04: {e_wl, e_ws, e_wg, e_glb, e_gl, e_gs} = 6'b010001;
      'h10: {e_wl, e_ws, e_wg, e_glb, e_gl, e_gs} = 6'b110011;
      'h11: {e_wl, e_ws, e_wg, e_glb, e_gl, e_gs} = 6'b100011;
      'h12: {e_wl, e_ws, e_wg, e_glb, e_gl, e_gs} = 6'b110001;
      'h13: {e_wl, e_ws, e_wg, e_glb, e_gl, e_gs} = 6'b100010;
      'h14: if (gi) {e_wl, e_ws, e_wg, e_glb, e_gl, e_gs} = 6'b111011;
      default: ;
    endcase
  endtask

  task automatic tick(input bit v, input int cls, input int bt,
                      input bit [2:0] oa, input bit [2:0] ga, input bit va);
    bit dn, acc, bar;
    dn  = mp && m_clear();
    acc = v && m_ready(cls);
    bar = acc && cls == 4;
    for (int c = 0; c < 3; c++) begin
      int inc, on, gn;
      inc = (acc && cls == c) ? 1 : 0;
      on  = oc[c] + inc - ((oa[c] && oc[c] > 0) ? 1 : 0);
      gn  = gc[c] + inc - ((ga[c] && gc[c] > 0) ? 1 : 0);
      if (bar) begin od[c] = on; gd[c] = gn; end
      else begin
        if (oa[c] && od[c] > 0) od[c]--;
        if (ga[c] && gd[c] > 0) gd[c]--;
      end
      oc[c] = on; gc[c] = gn;
    end
    begin
      int vn;
      vn = vc + ((acc && cls == 3) ? 1 : 0) - ((va && vc > 0) ? 1 : 0);
      if (bar) vd = vn;
      else if (va && vd > 0) vd--;
      vc = vn;
    end
    if (bar) begin mp = 1'b1; set_cfg(bt, gi_enable); end
    else if (dn) mp = 1'b0;
    md = dn;
  endtask

  task automatic step(input bit v, input int cls, input int bt,
                      input bit [2:0] oa, input bit [2:0] ga, input bit va, input string tag);
    chk(bar_pending, mp, tag, "bar_pending");
    chk(bar_done, md, tag, "bar_done");
    iss_valid = v; iss_class = 3'(cls); iss_btype = 5'(bt);
    ord_ack = oa; glb_ack = ga; ginv_ack = va;
    #1;
    chk(iss_ready, m_ready(cls), tag, $sformatf("iss_ready class %0d", cls));
    @(posedge clk);
    tick(v, cls, bt, oa, ga, va);
    @(negedge clk);
  endtask

  task automatic drain_all(input string tag);
    for (int k = 0; k < 80; k++) begin
      bit [2:0] oa, ga;
      if (!mp && vc == 0 && oc[0] + oc[1] + oc[2] + gc[0] + gc[1] + gc[2] == 0) break;
      for (int c = 0; c < 3; c++) begin oa[c] = oc[c] > 0; ga[c] = gc[c] > 0; end
      step(1'b0, 5, 0, oa, ga, vc > 0, tag);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int types[10];
    bit gis[10];
    string tags[10];
    types = '{'h00, 'h04, 'h10, 'h11, 'h12, 'h13, 'h14, 'h14, 'h07, 'h1A};
    gis   = '{0, 0, 0, 0, 0, 0, 1, 0, 1, 1};
    tags  = '{"R4", "R5", "R6", "R7", "R8", "R9", "R10", "R10", "R11", "R11"};
    void'($urandom(32'd20240611));
    for (int c = 0; c < 3; c++) begin oc[c] = 0; gc[c] = 0; od[c] = 0; gd[c] = 0; end
    vc = 0; vd = 0; mp = 0; md = 0;
    set_cfg(0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(bar_pending, 1'b0, "R1", "bar_pending after reset");
    chk(bar_done, 1'b0, "R1", "bar_done after reset");
    for (int c = 0; c < 8; c++) begin
      iss_class = 3'(c);
      #1 chk(iss_ready, 1'b1, "R1", $sformatf("iss_ready class %0d after reset", c));
    end
    @(negedge clk);

    // R3: capacity stall and recovery
    for (int k = 0; k < CAP; k++) step(1'b1, 0, 0, 3'b000, 3'b000, 1'b0, "R3");
    step(1'b1, 0, 0, 3'b000, 3'b000, 1'b0, "R3");
    step(1'b1, 0, 0, 3'b001, 3'b000, 1'b0, "R3");
    step(1'b1, 0, 0, 3'b001, 3'b001, 1'b0, "R3");
    drain_all("R3");
    // R3: ack with nothing outstanding is ignored
    step(1'b0, 5, 0, 3'b010, 3'b010, 1'b1, "R3");
    step(1'b1, 1, 0, 3'b000, 3'b000, 1'b0, "R3");
    step(1'b1, 4, 'h04, 3'b000, 3'b000, 1'b0, "R5");
    step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, "R3");
    step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, "R3");
    step(1'b0, 5, 0, 3'b010, 3'b000, 1'b0, "R3");
    drain_all("R13");

    // per-type scenarios
    for (int i = 0; i < 10; i++) begin
      gi_enable = gis[i];
      step(1'b1, 0, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b1, 1, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b1, 2, 0, 3'b000, 3'b000, 1'b0, "R12");
      step(1'b1, 3, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b1, 4, types[i], 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b1, 4, 0, 3'b000, 3'b000, 1'b0, "R13");
      step(1'b1, 0, 0, 3'b000, 3'b000, 1'b0, "R14");
      step(1'b1, 1, 0, 3'b000, 3'b000, 1'b0, "R14");
      step(1'b1, 2, 0, 3'b000, 3'b000, 1'b0, "R12");
      step(1'b1, 6, 0, 3'b000, 3'b000, 1'b0, "R2");
      step(1'b0, 5, 0, 3'b111, 3'b000, 1'b0, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b111, 1'b0, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b000, 1'b1, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      step(1'b0, 5, 0, 3'b000, 3'b000, 1'b0, tags[i]);
      drain_all("R13");
    end

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int cls, bt;
      bit [2:0] oa, ga;
      cls = int'($urandom_range(0, 6));
      bt  = types[$urandom_range(0, 9)];
      if ($urandom_range(0, 3) == 0) bt = int'($urandom_range(0, 31));
      if ($urandom_range(0, 63) == 0) gi_enable = ~gi_enable;
      for (int c = 0; c < 3; c++) begin
        oa[c] = ($urandom_range(0, 2) == 0);
        ga[c] = ($urandom_range(0, 2) == 0);
      end
      step($urandom_range(0, 1) == 1, cls, bt, oa, ga, $urandom_range(0, 3) == 0, "R14");
    end
    drain_all("R13");
    finish_run();
  end

endmodule